// File: doc/BRIEF.md
# Adaptive White/Black Level Expander

This block stretches the luma of a 10-bit YCbCr 4:4:4 pixel stream field by field. While a field streams through, it tracks three statistics over the valid pixels: the brightest luma, the darkest luma and the mean luma (the average picture level). When the next field starts, these values are frozen. They then drive the transfer curve for that whole new field. Luma above a white knee is stretched so that the previous field's brightest value lands on full scale. Luma below a black knee is stretched so that the previous field's darkest value lands on zero. Luma between the knees passes through untouched.

The controller sets the two knees and a global enable. The mean luma moves the knees: a bright picture lifts the white knee, and a dark picture lowers the black knee, so that the mid-tones of the scene are never stretched. The mean is a shift of the accumulated sum, which assumes a power-of-two active area set by a parameter. Chroma is not processed, but it is delayed so that it stays aligned with the luma.

Top module: `luma_level_expander`

## Requirements
- R1: Every output (valid, field start, luma, chroma) appears exactly 3 clock cycles after the matching input. After reset, out_valid, out_fstart and all data outputs are 0.
- R2: out_cb and out_cr equal in_cb and in_cr from 3 cycles earlier, bit for bit.
- R3: With cfg_en low, out_y equals in_y from 3 cycles earlier, whatever the statistics are.
- R4: Statistics cover only cycles where in_valid is 1. A cycle with in_valid=1 and in_fstart=1 ends the previous field and counts as the first pixel of the new one. Luma on cycles with in_valid=0 has no effect on any later output.
- R5: Let Wk be the effective white knee and Pw the previous field's maximum luma. If Pw > Wk and y > Wk, then out = Wk + (((y-Wk) * floor(((1023-Wk)*256)/(Pw-Wk))) >> 8).
- R6: Let Bk be the effective black knee and Pb the previous field's minimum luma. If Pb < Bk, y < Bk and R5 does not apply, then out = Bk - (((Bk-y) * floor((Bk*256)/(Bk-Pb))) >> 8).
- R7: Luma that falls under neither R5 nor R6 passes through unchanged. This includes luma above Wk when Pw <= Wk, and luma below Bk when Pb >= Bk.
- R8: Let A = min(floor(sum of the previous field's luma / 2^LOG2_PIX), 1023). Then Wk = max(cfg_white_pivot, A) and Bk = min(cfg_black_pivot, A).
- R9: The expanded result saturates: a white result above 1023 gives 1023, and a black drop of Bk or more gives 0.
- R10: The first field after reset sees a maximum of 0, a minimum of 1023 and a mean of 0, so its luma passes through unchanged.
- R11: The curve for a field depends only on the statistics of the field immediately before it, not on its own pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel qualifier |
| in_fstart | input | 1 | First pixel of a field (qualified by in_valid) |
| in_y | input | 10 | Input luma |
| in_cb | input | 10 | Input blue-difference chroma |
| in_cr | input | 10 | Input red-difference chroma |
| cfg_en | input | 1 | Expansion enable |
| cfg_white_pivot | input | 10 | White knee setting |
| cfg_black_pivot | input | 10 | Black knee setting |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_fstart | output | 1 | Delayed field start |
| out_y | output | 10 | Expanded luma |
| out_cb | output | 10 | Delayed blue-difference chroma |
| out_cr | output | 10 | Delayed red-difference chroma |

## Verification
The hardest cases to reach from the ports are saturation and the knee shift driven by the mean. Saturation needs a field whose luma goes beyond the peaks of the field before it. The knee shift needs the previous field's mean to sit outside the configured knees. The bench runs a 64-field sweep in which each field covers the next 16 luma codes, in a permuted order, under knee settings that change per field. Each field therefore overshoots its predecessor's peak, and all 1024 luma codes pass through the curve. Dedicated fields add idle cycles that carry 0 and 1023 inside a field, and a bright field followed by a dark one, to move the knees through the mean.

// File: rtl/lle_pkg.sv
package lle_pkg;

  typedef enum logic [1:0] {
    ZONE_MID   = 2'd0,
    ZONE_WHITE = 2'd1,
    ZONE_BLACK = 2'd2
  } lle_zone_e;

endpackage

// File: rtl/lle_delay.sv
module lle_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      logic [W-1:0] stage_d [DEPTH];

      always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
          stage_d[i] = stage_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            stage_q[i] <= '0;
          end
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            stage_q[i] <= stage_d[i];
          end
        end
      end

      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/lle_stats.sv
module lle_stats #(
  parameter int DW       = 10,
  parameter int LOG2_PIX = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_fstart,
  input  logic [DW-1:0] pix_y,
  output logic [DW-1:0] snap_max,
  output logic [DW-1:0] snap_min,
  output logic [DW-1:0] snap_apl
);

  localparam int          SW   = DW + LOG2_PIX + 1;
  localparam logic [DW-1:0] YMAX = {DW{1'b1}};

  logic [DW-1:0] acc_max_q, acc_max_d;
  logic [DW-1:0] acc_min_q, acc_min_d;
  logic [SW-1:0] acc_sum_q, acc_sum_d;
  logic [DW-1:0] snap_max_q, snap_min_q, snap_apl_q;
  logic [SW-1:0] apl_full;
  logic [DW-1:0] apl_now;
  logic [SW-1:0] y_ext;
  logic          acc_en, snap_en;

  assign y_ext    = {{(SW-DW){1'b0}}, pix_y};
  assign apl_full = acc_sum_q >> LOG2_PIX;
  assign apl_now  = (|apl_full[SW-1:DW]) ? YMAX : apl_full[DW-1:0];

  always_comb begin
    acc_en    = pix_valid;
    snap_en   = pix_valid & pix_fstart;
    if (pix_fstart) begin
      acc_max_d = pix_y;
      acc_min_d = pix_y;
      acc_sum_d = y_ext;
    end else begin
      acc_max_d = (pix_y > acc_max_q) ? pix_y : acc_max_q;
      acc_min_d = (pix_y < acc_min_q) ? pix_y : acc_min_q;
      acc_sum_d = acc_sum_q + y_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_max_q <= '0;
      acc_min_q <= YMAX;
      acc_sum_q <= '0;
    end else if (acc_en) begin
      acc_max_q <= acc_max_d;
      acc_min_q <= acc_min_d;
      acc_sum_q <= acc_sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_max_q <= '0;
      snap_min_q <= YMAX;
      snap_apl_q <= '0;
    end else if (snap_en) begin
      snap_max_q <= acc_max_q;
      snap_min_q <= acc_min_q;
      snap_apl_q <= apl_now;
    end
  end

  assign snap_max = snap_max_q;
  assign snap_min = snap_min_q;
  assign snap_apl = snap_apl_q;

endmodule

// File: rtl/lle_gain.sv
module lle_gain #(
  parameter int DW   = 10,
  parameter int FRAC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    peak_hi,
  input  logic [DW-1:0]    peak_lo,
  input  logic [DW-1:0]    apl,
  input  logic [DW-1:0]    piv_w,
  input  logic [DW-1:0]    piv_b,
  output logic [DW-1:0]    knee_w,
  output logic [DW-1:0]    knee_b,
  output logic             w_on,
  output logic             b_on,
  output logic [DW+FRAC-1:0] gain_w,
  output logic [DW+FRAC-1:0] gain_b
);

  localparam int            GW   = DW + FRAC;
  localparam logic [DW-1:0] YMAX = {DW{1'b1}};

  logic [DW-1:0] knee_w_d, knee_b_d, knee_w_q, knee_b_q;
  logic          w_on_d, b_on_d, w_on_q, b_on_q;
  logic [DW-1:0] w_span, b_span;
  logic [GW-1:0] w_num, b_num, w_den, b_den;
  logic [GW-1:0] gain_w_d, gain_b_d, gain_w_q, gain_b_q;

  always_comb begin
    knee_w_d = (apl > piv_w) ? apl : piv_w;
    knee_b_d = (apl < piv_b) ? apl : piv_b;
    w_on_d   = peak_hi > knee_w_d;
    b_on_d   = peak_lo < knee_b_d;
    w_span   = w_on_d ? (peak_hi - knee_w_d) : {{(DW-1){1'b0}}, 1'b1};
    b_span   = b_on_d ? (knee_b_d - peak_lo) : {{(DW-1){1'b0}}, 1'b1};
    w_num    = {YMAX - knee_w_d, {FRAC{1'b0}}};
    b_num    = {knee_b_d, {FRAC{1'b0}}};
    w_den    = {{FRAC{1'b0}}, w_span};
    b_den    = {{FRAC{1'b0}}, b_span};
    gain_w_d = w_num / w_den;
    gain_b_d = b_num / b_den;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      knee_w_q <= YMAX;
      knee_b_q <= '0;
      w_on_q   <= 1'b0;
      b_on_q   <= 1'b0;
      gain_w_q <= '0;
      gain_b_q <= '0;
    end else begin
      knee_w_q <= knee_w_d;
      knee_b_q <= knee_b_d;
      w_on_q   <= w_on_d;
      b_on_q   <= b_on_d;
      gain_w_q <= gain_w_d;
      gain_b_q <= gain_b_d;
    end
  end

  assign knee_w = knee_w_q;
  assign knee_b = knee_b_q;
  assign w_on   = w_on_q;
  assign b_on   = b_on_q;
  assign gain_w = gain_w_q;
  assign gain_b = gain_b_q;

endmodule

// File: rtl/lle_curve.sv
module lle_curve
  import lle_pkg::*;
#(
  parameter int DW   = 10,
  parameter int FRAC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [DW-1:0]      y_in,
  input  logic [DW-1:0]      knee_w,
  input  logic [DW-1:0]      knee_b,
  input  logic               w_on,
  input  logic               b_on,
  input  logic [DW+FRAC-1:0] gain_w,
  input  logic [DW+FRAC-1:0] gain_b,
  output logic [DW-1:0]      y_out
);

  localparam int            GW   = DW + FRAC;
  localparam int            PW   = DW + GW;
  localparam logic [DW-1:0] YMAX = {DW{1'b1}};

  lle_zone_e     zone;
  logic [DW-1:0] w_diff, b_diff, w_val, b_val;
  logic [PW-1:0] w_prod, w_lift, w_sum;
  logic [PW-1:0] b_prod, b_drop;
  logic [DW-1:0] y_d, y_q;

  always_comb begin
    if (en && w_on && (y_in > knee_w)) begin
      zone = ZONE_WHITE;
    end else if (en && b_on && (y_in < knee_b)) begin
      zone = ZONE_BLACK;
    end else begin
      zone = ZONE_MID;
    end

    w_diff = y_in - knee_w;
    w_prod = {{GW{1'b0}}, w_diff} * {{DW{1'b0}}, gain_w};
    w_lift = w_prod >> FRAC;
    w_sum  = {{GW{1'b0}}, knee_w} + w_lift;
    w_val  = (w_sum > {{GW{1'b0}}, YMAX}) ? YMAX : w_sum[DW-1:0];

    b_diff = knee_b - y_in;
    b_prod = {{GW{1'b0}}, b_diff} * {{DW{1'b0}}, gain_b};
    b_drop = b_prod >> FRAC;
    b_val  = (b_drop >= {{GW{1'b0}}, knee_b}) ? '0 : (knee_b - b_drop[DW-1:0]);

    unique case (zone)
      ZONE_WHITE: y_d = w_val;
      ZONE_BLACK: y_d = b_val;
      default:    y_d = y_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else begin
      y_q <= y_d;
    end
  end

  assign y_out = y_q;

endmodule

// File: rtl/luma_level_expander.sv
module luma_level_expander #(
  parameter int DW       = 10,
  parameter int LOG2_PIX = 18,
  parameter int FRAC     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_fstart,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  input  logic          cfg_en,
  input  logic [DW-1:0] cfg_white_pivot,
  input  logic [DW-1:0] cfg_black_pivot,
  output logic          out_valid,
  output logic          out_fstart,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);

  localparam int LAT    = 3;
  localparam int Y_LAT  = LAT - 1;
  localparam int SIDE_W = 2 * DW + 2;
  localparam int GW     = DW + FRAC;

  logic [DW-1:0]     st_max, st_min, st_apl;
  logic [DW-1:0]     knee_w, knee_b;
  logic              w_on, b_on;
  logic [GW-1:0]     gain_w, gain_b;
  logic [DW-1:0]     y_aligned;
  logic [SIDE_W-1:0] side_in, side_out;

  lle_stats #(.DW(DW), .LOG2_PIX(LOG2_PIX)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (in_valid),
    .pix_fstart (in_fstart),
    .pix_y      (in_y),
    .snap_max   (st_max),
    .snap_min   (st_min),
    .snap_apl   (st_apl)
  );

  lle_gain #(.DW(DW), .FRAC(FRAC)) u_gain (
    .clk     (clk),
    .rst_n   (rst_n),
    .peak_hi (st_max),
    .peak_lo (st_min),
    .apl     (st_apl),
    .piv_w   (cfg_white_pivot),
    .piv_b   (cfg_black_pivot),
    .knee_w  (knee_w),
    .knee_b  (knee_b),
    .w_on    (w_on),
    .b_on    (b_on),
    .gain_w  (gain_w),
    .gain_b  (gain_b)
  );

  lle_delay #(.W(DW), .DEPTH(Y_LAT)) u_ydly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (in_y),
    .dout  (y_aligned)
  );

  lle_curve #(.DW(DW), .FRAC(FRAC)) u_curve (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .y_in   (y_aligned),
    .knee_w (knee_w),
    .knee_b (knee_b),
    .w_on   (w_on),
    .b_on   (b_on),
    .gain_w (gain_w),
    .gain_b (gain_b),
    .y_out  (out_y)
  );

  assign side_in = {in_valid, in_fstart, in_cb, in_cr};

  lle_delay #(.W(SIDE_W), .DEPTH(LAT)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (side_in),
    .dout  (side_out)
  );

  assign out_valid  = side_out[SIDE_W-1];
  assign out_fstart = side_out[SIDE_W-2];
  assign out_cb     = side_out[2*DW-1:DW];
  assign out_cr     = side_out[DW-1:0];

endmodule

// File: rtl/lle_checker.sv
module lle_checker #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_fstart,
  input logic [DW-1:0] in_y,
  input logic [DW-1:0] in_cb,
  input logic [DW-1:0] in_cr,
  input logic          cfg_en,
  input logic [DW-1:0] cfg_white_pivot,
  input logic [DW-1:0] cfg_black_pivot,
  input logic          out_valid,
  input logic          out_fstart,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R1: qualifiers follow the inputs by exactly three cycles
  p_ctrl_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)) && (out_fstart == $past(in_fstart, 3)));

  // R2: chroma is a pure three-cycle delay
  p_chroma_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_cb == $past(in_cb, 3)) && (out_cr == $past(in_cr, 3)));

  // R3: disabled expansion leaves luma untouched
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(cfg_en)) |-> (out_y == $past(in_y, 3)));

  // R5: luma at or above the white setting is never lowered
  p_white_lift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(cfg_en)
     && $past(cfg_black_pivot, 2) <= $past(cfg_white_pivot, 2)
     && $past(in_y, 3) >= $past(cfg_white_pivot, 2)) |-> (out_y >= $past(in_y, 3)));

  // R6: luma at or below the black setting is never raised
  p_black_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(cfg_en)
     && $past(cfg_black_pivot, 2) <= $past(cfg_white_pivot, 2)
     && $past(in_y, 3) <= $past(cfg_black_pivot, 2)) |-> (out_y <= $past(in_y, 3)));

endmodule

bind luma_level_expander lle_checker #(.DW(DW)) u_lle_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_fstart       (in_fstart),
  .in_y            (in_y),
  .in_cb           (in_cb),
  .in_cr           (in_cr),
  .cfg_en          (cfg_en),
  .cfg_white_pivot (cfg_white_pivot),
  .cfg_black_pivot (cfg_black_pivot),
  .out_valid       (out_valid),
  .out_fstart      (out_fstart),
  .out_y           (out_y),
  .out_cb          (out_cb),
  .out_cr          (out_cr)
);

// File: tb/luma_level_expander_tb.sv
module luma_level_expander_tb;

  localparam int NPIX = 16;
  localparam int QD   = 4096;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_fstart, cfg_en;
  logic [9:0] in_y, in_cb, in_cr, cfg_white_pivot, cfg_black_pivot;
  logic       out_valid, out_fstart;
  logic [9:0] out_y, out_cb, out_cr;

  always #10 clk = ~clk;

  luma_level_expander #(.DW(10), .LOG2_PIX(4), .FRAC(8)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_fstart (in_fstart),
    .in_y (in_y), .in_cb (in_cb), .in_cr (in_cr),
    .cfg_en (cfg_en), .cfg_white_pivot (cfg_white_pivot), .cfg_black_pivot (cfg_black_pivot),
    .out_valid (out_valid), .out_fstart (out_fstart),
    .out_y (out_y), .out_cb (out_cb), .out_cr (out_cr)
  );

  int    checks = 0, failures = 0;
  int    cyc = 0;
  bit    started = 0;
  int    pmax = 0, pmin = 1023, papl = 0;
  int    pix [NPIX];
  int    e_y [QD], e_cb [QD], e_cr [QD], e_cyc [QD], e_fs [QD];
  string e_tag [QD];
  int    wr = 0, rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected luma from the requirement formulas, using previous-field stats.
  function automatic int model(input int y, input int en, input int wp, input int bp,
                               output string tg);
    int wk, bk, g, v;
    tg = "R7";
    if (!en) begin tg = "R3"; return y; end
    wk = (papl > wp) ? papl : wp;   // R8
    bk = (papl < bp) ? papl : bp;
    if (pmax > wk && y > wk) begin
      g = ((1023 - wk) * 256) / (pmax - wk);
      v = wk + (((y - wk) * g) >> 8);
      if (v > 1023) begin tg = "R9"; return 1023; end
      tg = "R5";
      return v;
    end
    if (pmin < bk && y < bk) begin
      g = (bk * 256) / (bk - pmin);
      v = bk - (((bk - y) * g) >> 8);
      if (v < 0) begin tg = "R9"; return 0; end
      tg = "R6";
      return v;
    end
    return y;
  endfunction

  task automatic drive(input bit v, input bit fs, input int y, input int cb, input int cr);
    in_valid  = v;
    in_fstart = fs;
    in_y      = y[9:0];
    in_cb     = cb[9:0];
    in_cr     = cr[9:0];
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, (cyc * 37) % 1024, 5, 6);
  endtask

  task automatic send_field(input int en, input int wp, input int bp, input bit gaps,
                            input string force_tag);
    string tg;
    int    ey, sum, mx, mn;
    cfg_en          = en[0];
    cfg_white_pivot = wp[9:0];
    cfg_black_pivot = bp[9:0];
    idle(2);
    sum = 0; mx = 0; mn = 1023;
    for (int i = 0; i < NPIX; i++) begin
      if (gaps && (i % 3 == 1)) drive(1'b0, (i % 2) == 0, (i % 2) ? 0 : 1023, 1, 2);
      ey = model(pix[i], en, wp, bp, tg);
      if (force_tag != "") tg = force_tag;
      e_y[wr % QD]   = ey;
      e_cb[wr % QD]  = (pix[i] * 3 + 7) % 1024;
      e_cr[wr % QD]  = 1023 - pix[i];
      e_cyc[wr % QD] = cyc + 3;
      e_fs[wr % QD]  = (i == 0);
      e_tag[wr % QD] = tg;
      wr++;
      drive(1'b1, i == 0, pix[i], (pix[i] * 3 + 7) % 1024, 1023 - pix[i]);
      sum += pix[i];
      if (pix[i] > mx) mx = pix[i];
      if (pix[i] < mn) mn = pix[i];
    end
    pmax = mx;
    pmin = mn;
    papl = ((sum >> 4) > 1023) ? 1023 : (sum >> 4);
    idle(5);
  endtask

  // Output monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (started) begin
      if (out_valid) begin
        if (rd >= wr) begin
          chk(1'b0, "R1", "unexpected out_valid", 1, 0);
        end else begin
          chk(cyc == e_cyc[rd % QD], "R1", "output cycle", cyc, e_cyc[rd % QD]);
          chk(int'(out_fstart) == e_fs[rd % QD], "R1", "out_fstart", int'(out_fstart), e_fs[rd % QD]);
          chk(int'(out_y) == e_y[rd % QD], e_tag[rd % QD], "out_y", int'(out_y), e_y[rd % QD]);
          chk(int'(out_cb) == e_cb[rd % QD] && int'(out_cr) == e_cr[rd % QD], "R2", "chroma cb",
              int'(out_cb), e_cb[rd % QD]);
          rd++;
        end
      end else if (rd < wr && cyc > e_cyc[rd % QD]) begin
        chk(1'b0, "R1", "missing output", cyc, e_cyc[rd % QD]);
        rd++;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_fstart = 0; in_y = 0; in_cb = 0; in_cr = 0;
    cfg_en = 1; cfg_white_pivot = 700; cfg_black_pivot = 200;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && out_fstart == 0, "R1", "reset qualifiers", int'(out_valid), 0);
    chk(out_y == 0 && out_cb == 0 && out_cr == 0, "R1", "reset data", int'(out_y), 0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;

    // R10: first field after reset passes unchanged
    for (int i = 0; i < NPIX; i++) pix[i] = 60 * i + 20;
    send_field(1, 700, 200, 0, "R10");
    // R11: same ramp again, now shaped by the previous field only
    send_field(1, 700, 200, 0, "R11");
    // R4: idle cycles carrying 0 and 1023 inside the field
    for (int i = 0; i < NPIX; i++) pix[i] = 300 + 25 * i;
    send_field(1, 650, 350, 1, "");
    for (int i = 0; i < NPIX; i++) pix[i] = (i * 68) % 1024;
    send_field(1, 600, 400, 0, "R4");
    // R3: disabled, with bright content to set a high mean
    for (int i = 0; i < NPIX; i++) pix[i] = 640 + 20 * i;
    send_field(0, 500, 300, 0, "R3");
    // R8: high mean lifts the white knee; dark content sets a low mean
    for (int i = 0; i < NPIX; i++) pix[i] = 40 + 10 * i;
    send_field(1, 300, 250, 0, "R8");
    for (int i = 0; i < NPIX; i++) pix[i] = 20 * i + 5;
    send_field(1, 900, 400, 0, "R8");
    // Sweep of all luma codes, one 16-code slice per field, varying knees
    for (int k = 0; k < 64; k++) begin
      for (int i = 0; i < NPIX; i++) pix[i] = k * 16 + ((i * 5) % 16);
      send_field(1, 512 + (k * 7) % 300, 100 + (k * 13) % 300, 0, "");
    end
    idle(4);
    chk(rd == wr, "R1", "all outputs seen", rd, wr);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule